// File: doc/BRIEF.md
# Queue-Port Messaging Unit

This block sits between a host bus slave port and a local processor. The host sees a small register window. Two 32-bit queue ports in that window carry all request traffic. Reading the inbound queue port hands the host the offset of a free request frame in local memory. Writing the same port posts a request word to the processor. The outbound queue port also works both ways. Reading it returns the next completion word. Writing it hands a local frame back to the free pool.

A posted word with bit 31 set names a request held in host memory. Bits 30:0 of that word hold the bus address shifted right by five, so such requests must sit on 32-byte boundaries. The unit passes every word through unchanged and never parses it.

Besides the queues, the unit has the following registers:
- message registers, used for commands that are not queued;
- a host-to-processor doorbell;
- two status/mask register pairs.

The outbound pair drives the host interrupt line. The inbound pair drives the processor interrupt line. All three FIFOs are the same parameterised circular buffer. A push to a full buffer is lost and sets a sticky overflow flag that the processor can see.

Top module: `qpmu_top`

## Requirements
- R1: After reset, the unit is in this state:
  - both mask registers (0x28 inbound, 0x34 outbound) read 0xFFFFFFFF;
  - both status registers (0x24, 0x30), the messages and the doorbell read 0;
  - all FIFOs are empty;
  - `p_ovf_o` is 0;
  - both interrupt lines are low.
- R2: A host read of 0x40 returns the head of the free-frame FIFO and pops it, in push order. If that FIFO is empty, the read returns 0xFFFFFFFF and pops nothing.
- R3: A push to a full FIFO is dropped and leaves the stored words intact. It sets a sticky bit in `p_ovf_o`: bit 0 for the free FIFO, bit 1 for the post FIFO, bit 2 for the completion FIFO. Only reset clears these bits.
- R4: A host write to 0x40 pushes the word unchanged into the post FIFO, including words tagged with bit 31. While that FIFO holds data, `p_post_valid_o` is 1 and `p_post_data_o` shows the oldest word. `p_post_pop_i` removes that word.
- R5: `p_cmpl_push_i` pushes `p_cmpl_data_i` into the completion FIFO. A host read of 0x44 pops the completions in push order. If the completion FIFO is empty, the read returns 0xFFFFFFFF.
- R6: A host write to 0x44 pushes the word into the free FIFO. If `p_free_push_i` is high in the same cycle, the host word is stored, the processor word is dropped, and `p_ovf_o` bit 0 is set.
- R7: Some status bits follow live conditions:
  - outbound status bit 3 is 1 exactly while the completion FIFO is non-empty;
  - inbound status bit 4 is 1 exactly while the post FIFO is non-empty;
  - inbound status bit 2 is 1 exactly while any doorbell bit is set.
- R8: `host_irq_o` is the OR of the outbound status bits whose outbound mask bit is 0. `p_irq_o` is the OR of the inbound status bits whose inbound mask bit is 0. The host writes both masks.
- R9: The message handshake for non-queued commands works as follows:
  - A host write to 0x10 loads inbound message 0 and sets inbound status bit 0. A pulse on `p_imsg_ack_i` clears that bit.
  - A processor write to outbound message 0 (`p_omsg_wr_i[0]`) sets outbound status bit 0, but only when the value written equals inbound message 0.
  - Writing 1 to bit 0 of 0x30 clears outbound status bit 0.
- R10: A host write to 0x20 sets the written doorbell bits. `p_db_clr_i` clears doorbell bits. When both touch the same bit in the same cycle, the set wins.
- R11: The remaining message registers and unmapped addresses behave as follows:
  - inbound message 1 (0x14) is written by the host and shown on `p_imsg1_o`;
  - outbound messages 0 and 1 (0x18, 0x1C) are written by the processor and read by the host;
  - unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_rd_i | input | 1 | Host read strobe |
| h_wr_i | input | 1 | Host write strobe |
| h_addr_i | input | 8 | Host byte address |
| h_wdata_i | input | 32 | Host write data |
| h_rdata_o | output | 32 | Host read data, valid in the strobe cycle |
| host_irq_o | output | 1 | Host interrupt |
| p_post_pop_i | input | 1 | Processor pops the post FIFO |
| p_post_valid_o | output | 1 | Post FIFO holds data |
| p_post_data_o | output | 32 | Oldest posted word |
| p_cmpl_push_i | input | 1 | Processor pushes a completion |
| p_cmpl_data_i | input | 32 | Completion word |
| p_free_push_i | input | 1 | Processor loads a free frame |
| p_free_data_i | input | 32 | Free frame offset |
| p_omsg_wr_i | input | 2 | Write outbound message 0 / 1 |
| p_omsg_data_i | input | 32 | Outbound message data |
| p_imsg_ack_i | input | 1 | Clears inbound message pending |
| p_imsg0_o | output | 32 | Inbound message 0 |
| p_imsg1_o | output | 32 | Inbound message 1 |
| p_db_clr_i | input | 32 | Doorbell clear bits |
| p_db_o | output | 32 | Doorbell bits |
| p_irq_o | output | 1 | Processor interrupt |
| p_ovf_o | output | 3 | Sticky overflow flags |

## Verification
The hardest case to reach is the free FIFO being fed from both of its sources in one cycle. A host recycle write and a processor load must arrive on the same clock edge. The bench therefore drives both strobes in a single cycle right after a fresh reset, so the overflow bit can only come from the collision. It then drains the FIFO to prove which word survived.

Each FIFO is also swept through every fill level up to its small bench depth, plus one push beyond full. This reaches the drop path and the empty-read sentinel.

// File: rtl/qpmu_pkg.sv
package qpmu_pkg;
  localparam int ADDR_W = 8;
  localparam int DW     = 32;

  localparam logic [ADDR_W-1:0] A_IMSG0 = 8'h10;
  localparam logic [ADDR_W-1:0] A_IMSG1 = 8'h14;
  localparam logic [ADDR_W-1:0] A_OMSG0 = 8'h18;
  localparam logic [ADDR_W-1:0] A_OMSG1 = 8'h1C;
  localparam logic [ADDR_W-1:0] A_DBELL = 8'h20;
  localparam logic [ADDR_W-1:0] A_ISTAT = 8'h24;
  localparam logic [ADDR_W-1:0] A_IMASK = 8'h28;
  localparam logic [ADDR_W-1:0] A_OSTAT = 8'h30;
  localparam logic [ADDR_W-1:0] A_OMASK = 8'h34;
  localparam logic [ADDR_W-1:0] A_INQ   = 8'h40;
  localparam logic [ADDR_W-1:0] A_OUTQ  = 8'h44;

  localparam int IS_MSG  = 0;
  localparam int IS_DB   = 2;
  localparam int IS_POST = 4;
  localparam int OS_MSG  = 0;
  localparam int OS_CMPL = 3;

  localparam logic [DW-1:0] EMPTY_WORD = '1;
endpackage

// File: rtl/qpmu_fifo.sv
module qpmu_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          drop_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp_q, rp_q;
  logic          do_push, do_pop;

  assign empty_o = (wp_q == rp_q);
  assign full_o  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign drop_o  = push_i && full_o;
  assign data_o  = mem[rp_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q[AW-1:0]] <= data_i;
  end
endmodule

// File: rtl/qpmu_irq.sv
module qpmu_irq #(
  parameter int W = 32
) (
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  // mask bit 1 disables the source
  assign irq_o = |(stat_i & ~mask_i);
endmodule

// File: rtl/qpmu_top.sv
module qpmu_top
  import qpmu_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              h_rd_i,
  input  logic              h_wr_i,
  input  logic [ADDR_W-1:0] h_addr_i,
  input  logic [DW-1:0]     h_wdata_i,
  output logic [DW-1:0]     h_rdata_o,
  output logic              host_irq_o,
  input  logic              p_post_pop_i,
  output logic              p_post_valid_o,
  output logic [DW-1:0]     p_post_data_o,
  input  logic              p_cmpl_push_i,
  input  logic [DW-1:0]     p_cmpl_data_i,
  input  logic              p_free_push_i,
  input  logic [DW-1:0]     p_free_data_i,
  input  logic [1:0]        p_omsg_wr_i,
  input  logic [DW-1:0]     p_omsg_data_i,
  input  logic              p_imsg_ack_i,
  output logic [DW-1:0]     p_imsg0_o,
  output logic [DW-1:0]     p_imsg1_o,
  input  logic [DW-1:0]     p_db_clr_i,
  output logic [DW-1:0]     p_db_o,
  output logic              p_irq_o,
  output logic [2:0]        p_ovf_o
);
  logic [DW-1:0] imsg0_q, imsg1_q, omsg0_q, omsg1_q, db_q;
  logic [DW-1:0] in_mask, out_mask, in_stat, out_stat;
  logic          imsg_pend_q, msg_done_q;
  logic [2:0]    ovf_q;

  logic          free_push, free_pop, free_empty, free_full, free_drop, free_clash;
  logic [DW-1:0] free_wdata, free_head;
  logic          post_push, post_empty, post_full, post_drop;
  logic          cmpl_pop, cmpl_empty, cmpl_full, cmpl_drop;
  logic [DW-1:0] cmpl_head;
  logic [DW-1:0] rd_data;

  logic wr_imsg0, wr_imsg1, wr_db, wr_imask, wr_ostat, wr_omask, wr_inq, wr_outq;
  assign wr_imsg0 = h_wr_i && (h_addr_i == A_IMSG0);
  assign wr_imsg1 = h_wr_i && (h_addr_i == A_IMSG1);
  assign wr_db    = h_wr_i && (h_addr_i == A_DBELL);
  assign wr_imask = h_wr_i && (h_addr_i == A_IMASK);
  assign wr_ostat = h_wr_i && (h_addr_i == A_OSTAT);
  assign wr_omask = h_wr_i && (h_addr_i == A_OMASK);
  assign wr_inq   = h_wr_i && (h_addr_i == A_INQ);
  assign wr_outq  = h_wr_i && (h_addr_i == A_OUTQ);

  // free FIFO: host recycle wins over processor load
  assign free_push  = wr_outq || p_free_push_i;
  assign free_wdata = wr_outq ? h_wdata_i : p_free_data_i;
  assign free_clash = wr_outq && p_free_push_i;
  assign free_pop   = h_rd_i && (h_addr_i == A_INQ);
  assign post_push  = wr_inq;
  assign cmpl_pop   = h_rd_i && (h_addr_i == A_OUTQ);

  qpmu_fifo #(.DW(DW), .DEPTH(DEPTH)) u_free (
    .clk_i, .rst_ni, .push_i(free_push), .data_i(free_wdata), .pop_i(free_pop),
    .data_o(free_head), .empty_o(free_empty), .full_o(free_full), .drop_o(free_drop));

  qpmu_fifo #(.DW(DW), .DEPTH(DEPTH)) u_post (
    .clk_i, .rst_ni, .push_i(post_push), .data_i(h_wdata_i), .pop_i(p_post_pop_i),
    .data_o(p_post_data_o), .empty_o(post_empty), .full_o(post_full), .drop_o(post_drop));

  qpmu_fifo #(.DW(DW), .DEPTH(DEPTH)) u_cmpl (
    .clk_i, .rst_ni, .push_i(p_cmpl_push_i), .data_i(p_cmpl_data_i), .pop_i(cmpl_pop),
    .data_o(cmpl_head), .empty_o(cmpl_empty), .full_o(cmpl_full), .drop_o(cmpl_drop));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imsg0_q     <= '0;
      imsg1_q     <= '0;
      omsg0_q     <= '0;
      omsg1_q     <= '0;
      db_q        <= '0;
      in_mask     <= '1;
      out_mask    <= '1;
      imsg_pend_q <= 1'b0;
      msg_done_q  <= 1'b0;
      ovf_q       <= '0;
    end else begin
      if (wr_imsg0) imsg0_q <= h_wdata_i;
      if (wr_imsg1) imsg1_q <= h_wdata_i;
      if (p_omsg_wr_i[0]) omsg0_q <= p_omsg_data_i;
      if (p_omsg_wr_i[1]) omsg1_q <= p_omsg_data_i;
      if (wr_imask) in_mask  <= h_wdata_i;
      if (wr_omask) out_mask <= h_wdata_i;
      db_q <= (db_q & ~p_db_clr_i) | (wr_db ? h_wdata_i : '0);
      if (wr_imsg0)          imsg_pend_q <= 1'b1;
      else if (p_imsg_ack_i) imsg_pend_q <= 1'b0;
      // completion match sets, host write-1 clears; set wins
      if (p_omsg_wr_i[0] && (p_omsg_data_i == imsg0_q)) msg_done_q <= 1'b1;
      else if (wr_ostat && h_wdata_i[OS_MSG])            msg_done_q <= 1'b0;
      ovf_q <= ovf_q | {cmpl_drop, post_drop, free_drop || free_clash};
    end
  end

  always_comb begin
    in_stat          = '0;
    in_stat[IS_MSG]  = imsg_pend_q;
    in_stat[IS_DB]   = |db_q;
    in_stat[IS_POST] = !post_empty;
    out_stat          = '0;
    out_stat[OS_MSG]  = msg_done_q;
    out_stat[OS_CMPL] = !cmpl_empty;
  end

  qpmu_irq #(.W(DW)) u_host_irq (.stat_i(out_stat), .mask_i(out_mask), .irq_o(host_irq_o));
  qpmu_irq #(.W(DW)) u_proc_irq (.stat_i(in_stat),  .mask_i(in_mask),  .irq_o(p_irq_o));

  always_comb begin
    case (h_addr_i)
      A_IMSG0: rd_data = imsg0_q;
      A_IMSG1: rd_data = imsg1_q;
      A_OMSG0: rd_data = omsg0_q;
      A_OMSG1: rd_data = omsg1_q;
      A_DBELL: rd_data = db_q;
      A_ISTAT: rd_data = in_stat;
      A_IMASK: rd_data = in_mask;
      A_OSTAT: rd_data = out_stat;
      A_OMASK: rd_data = out_mask;
      A_INQ:   rd_data = free_empty ? EMPTY_WORD : free_head;
      A_OUTQ:  rd_data = cmpl_empty ? EMPTY_WORD : cmpl_head;
      default: rd_data = '0;
    endcase
  end

  assign h_rdata_o      = h_rd_i ? rd_data : '0;
  assign p_post_valid_o = !post_empty;
  assign p_imsg0_o      = imsg0_q;
  assign p_imsg1_o      = imsg1_q;
  assign p_db_o         = db_q;
  assign p_ovf_o        = ovf_q;
endmodule

// File: rtl/qpmu_chk.sv
module qpmu_chk
  import qpmu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              h_rd_i,
  input logic              h_wr_i,
  input logic [ADDR_W-1:0] h_addr_i,
  input logic [DW-1:0]     h_wdata_i,
  input logic              free_empty,
  input logic              free_push,
  input logic              post_empty,
  input logic              p_post_pop_i,
  input logic              p_post_valid_o,
  input logic [DW-1:0]     p_post_data_o,
  input logic              cmpl_empty,
  input logic [DW-1:0]     out_stat,
  input logic [DW-1:0]     out_mask,
  input logic              host_irq_o,
  input logic [1:0]        p_omsg_wr_i,
  input logic [DW-1:0]     p_omsg_data_i,
  input logic [DW-1:0]     imsg0_q,
  input logic [DW-1:0]     p_db_o,
  input logic [2:0]        p_ovf_o
);
  p_empty_pop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_rd_i && h_addr_i == A_INQ && free_empty && !free_push) |=> free_empty);

  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_ovf_o != 3'b000) |=> ((p_ovf_o & $past(p_ovf_o)) == $past(p_ovf_o)));

  p_post_head_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_wr_i && h_addr_i == A_INQ && post_empty && !p_post_pop_i)
      |=> (p_post_valid_o && p_post_data_o == $past(h_wdata_i)));

  p_out_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_stat[OS_CMPL] == !cmpl_empty);

  p_host_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o == ((out_stat & ~out_mask) != '0));

  p_msg_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_omsg_wr_i[0] && p_omsg_data_i == imsg0_q) |=> out_stat[OS_MSG]);

  p_db_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_wr_i && h_addr_i == A_DBELL) |=> ((p_db_o & $past(h_wdata_i)) == $past(h_wdata_i)));
endmodule

bind qpmu_top qpmu_chk u_chk (
  .clk_i, .rst_ni, .h_rd_i, .h_wr_i, .h_addr_i, .h_wdata_i,
  .free_empty, .free_push, .post_empty, .p_post_pop_i, .p_post_valid_o, .p_post_data_o,
  .cmpl_empty, .out_stat, .out_mask, .host_irq_o, .p_omsg_wr_i, .p_omsg_data_i,
  .imsg0_q, .p_db_o, .p_ovf_o
);

// File: tb/qpmu_top_tb.sv
module qpmu_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_rd = 1'b0, h_wr = 1'b0;
  logic [7:0]  h_addr = '0;
  logic [31:0] h_wdata = '0, h_rdata;
  logic        host_irq;
  logic        post_pop = 1'b0, post_valid;
  logic [31:0] post_data;
  logic        cmpl_push = 1'b0, free_push = 1'b0;
  logic [31:0] cmpl_data = '0, free_data = '0;
  logic [1:0]  omsg_wr = '0;
  logic [31:0] omsg_data = '0;
  logic        imsg_ack = 1'b0;
  logic [31:0] imsg0, imsg1, db_clr = '0, db;
  logic        p_irq;
  logic [2:0]  ovf;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qpmu_top #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .h_rd_i(h_rd), .h_wr_i(h_wr), .h_addr_i(h_addr),
    .h_wdata_i(h_wdata), .h_rdata_o(h_rdata), .host_irq_o(host_irq),
    .p_post_pop_i(post_pop), .p_post_valid_o(post_valid), .p_post_data_o(post_data),
    .p_cmpl_push_i(cmpl_push), .p_cmpl_data_i(cmpl_data),
    .p_free_push_i(free_push), .p_free_data_i(free_data),
    .p_omsg_wr_i(omsg_wr), .p_omsg_data_i(omsg_data), .p_imsg_ack_i(imsg_ack),
    .p_imsg0_o(imsg0), .p_imsg1_o(imsg1), .p_db_clr_i(db_clr), .p_db_o(db),
    .p_irq_o(p_irq), .p_ovf_o(ovf));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic hwr(input logic [7:0] a, input logic [31:0] d);
    h_wr = 1'b1; h_addr = a; h_wdata = d;
    tick();
    h_wr = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [31:0] d);
    h_rd = 1'b1; h_addr = a;
    #1 d = h_rdata;
    tick();
    h_rd = 1'b0;
  endtask

  task automatic free_load(input logic [31:0] d);
    free_push = 1'b1; free_data = d;
    tick();
    free_push = 1'b0;
  endtask

  task automatic cmpl_load(input logic [31:0] d);
    cmpl_push = 1'b1; cmpl_data = d;
    tick();
    cmpl_push = 1'b0;
  endtask

  function automatic logic [31:0] frame(input int n, input int i);
    return 32'h1000 + 32'(n) * 32'h100 + 32'(i) * 32'h20;
  endfunction

  initial begin
    for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 host_irq", 32'(host_irq), 0);
    chk("R1 p_irq", 32'(p_irq), 0);
    chk("R1 ovf", 32'(ovf), 0);
    chk("R1 post_valid", 32'(post_valid), 0);
    hrd(8'h28, d); chk("R1 imask", d, 32'hFFFF_FFFF);
    hrd(8'h34, d); chk("R1 omask", d, 32'hFFFF_FFFF);
    hrd(8'h24, d); chk("R1 istat", d, 0);
    hrd(8'h30, d); chk("R1 ostat", d, 0);
    hrd(8'h20, d); chk("R1 doorbell", d, 0);
    hrd(8'h40, d); chk("R2 empty free read", d, 32'hFFFF_FFFF);
    hrd(8'h44, d); chk("R5 empty cmpl read", d, 32'hFFFF_FFFF);

    // R6 collision on the free FIFO right after reset
    free_push = 1'b1; free_data = 32'h400;
    hwr(8'h44, 32'h300);
    free_push = 1'b0;
    chk("R6 clash ovf", 32'(ovf), 32'b001);
    hrd(8'h40, d); chk("R6 host word kept", d, 32'h300);
    hrd(8'h40, d); chk("R6 proc word dropped", d, 32'hFFFF_FFFF);
    do_reset();
    hwr(8'h44, 32'h200);
    hrd(8'h40, d); chk("R6 recycle", d, 32'h200);
    chk("R6 no ovf", 32'(ovf), 0);

    // R2 sweep over all fill levels
    for (int n = 1; n <= DEPTH; n++) begin
      for (int i = 0; i < n; i++) free_load(frame(n, i));
      for (int i = 0; i < n; i++) begin
        hrd(8'h40, d); chk("R2 free order", d, frame(n, i));
      end
      hrd(8'h40, d); chk("R2 drained", d, 32'hFFFF_FFFF);
    end
    chk("R3 no ovf yet", 32'(ovf), 0);

    // R3 free overflow
    for (int i = 0; i <= DEPTH; i++) free_load(frame(9, i));
    chk("R3 free ovf", 32'(ovf), 32'b001);
    for (int i = 0; i < DEPTH; i++) begin
      hrd(8'h40, d); chk("R3 stored intact", d, frame(9, i));
    end
    hrd(8'h40, d); chk("R3 extra dropped", d, 32'hFFFF_FFFF);
    chk("R3 sticky", 32'(ovf), 32'b001);

    // R4 posts: alternate local offsets and host-memory tagged words
    for (int n = 1; n <= DEPTH; n++) begin
      for (int i = 0; i < n; i++)
        hwr(8'h40, (i % 2) ? (32'h8000_0000 | ((32'h1234_5600 + 32'(i) * 32'h40) >> 5)) : frame(n, i));
      hrd(8'h24, d); chk("R7 istat post", d, 32'h10);
      for (int i = 0; i < n; i++) begin
        chk("R4 post valid", 32'(post_valid), 1);
        chk("R4 post data", post_data,
            (i % 2) ? (32'h8000_0000 | ((32'h1234_5600 + 32'(i) * 32'h40) >> 5)) : frame(n, i));
        post_pop = 1'b1; tick(); post_pop = 1'b0;
      end
      chk("R4 post empty", 32'(post_valid), 0);
    end
    for (int i = 0; i <= DEPTH; i++) hwr(8'h40, frame(7, i));
    chk("R3 post ovf", 32'(ovf), 32'b011);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 post intact", post_data, frame(7, i));
      post_pop = 1'b1; tick(); post_pop = 1'b0;
    end

    // R5 / R7 / R8 completion path
    hwr(8'h34, ~32'h8);
    chk("R8 irq idle", 32'(host_irq), 0);
    cmpl_load(32'hCAFE_0001);
    chk("R8 irq raised", 32'(host_irq), 1);
    hrd(8'h30, d); chk("R7 ostat busy", d, 32'h8);
    hwr(8'h34, 32'hFFFF_FFFF);
    chk("R8 masked", 32'(host_irq), 0);
    hwr(8'h34, ~32'h8);
    for (int i = 1; i <= DEPTH; i++) cmpl_load(32'hCAFE_0001 + 32'(i));
    chk("R3 cmpl ovf", 32'(ovf), 32'b111);
    for (int i = 0; i < DEPTH; i++) begin
      hrd(8'h44, d); chk("R5 cmpl order", d, 32'hCAFE_0001 + 32'(i));
    end
    hrd(8'h44, d); chk("R5 cmpl drained", d, 32'hFFFF_FFFF);
    chk("R8 irq clear", 32'(host_irq), 0);
    hrd(8'h30, d); chk("R7 ostat idle", d, 0);

    // R9 message handshake
    hwr(8'h10, 32'hA5);
    chk("R9 imsg0", imsg0, 32'hA5);
    hrd(8'h24, d); chk("R9 istat msg", d, 32'h1);
    hwr(8'h28, ~32'h1);
    chk("R9 p_irq msg", 32'(p_irq), 1);
    imsg_ack = 1'b1; tick(); imsg_ack = 1'b0;
    chk("R9 ack", 32'(p_irq), 0);
    hwr(8'h34, ~32'h9);
    omsg_wr = 2'b01; omsg_data = 32'h5A; tick(); omsg_wr = '0;
    hrd(8'h30, d); chk("R9 mismatch", d, 0);
    chk("R9 no irq", 32'(host_irq), 0);
    hrd(8'h18, d); chk("R11 omsg0", d, 32'h5A);
    omsg_wr = 2'b01; omsg_data = 32'hA5; tick(); omsg_wr = '0;
    hrd(8'h30, d); chk("R9 match", d, 32'h1);
    chk("R9 host irq", 32'(host_irq), 1);
    hwr(8'h30, 32'h1);
    hrd(8'h30, d); chk("R9 w1c", d, 0);

    // R10 doorbell
    hwr(8'h20, 32'h3);
    hwr(8'h20, 32'h10);
    hrd(8'h20, d); chk("R10 w1s", d, 32'h13);
    hrd(8'h24, d); chk("R7 istat db", d, 32'h4);
    hwr(8'h28, ~32'h4);
    chk("R10 p_irq", 32'(p_irq), 1);
    db_clr = 32'h13; tick(); db_clr = '0;
    chk("R10 clear", db, 0);
    chk("R10 p_irq off", 32'(p_irq), 0);
    db_clr = 32'h1;
    hwr(8'h20, 32'h1);
    db_clr = '0;
    chk("R10 set wins", db, 32'h1);

    // R11 other registers
    hwr(8'h14, 32'hBEEF);
    chk("R11 imsg1", imsg1, 32'hBEEF);
    omsg_wr = 2'b10; omsg_data = 32'h7777; tick(); omsg_wr = '0;
    hrd(8'h1C, d); chk("R11 omsg1", d, 32'h7777);
    hrd(8'h3C, d); chk("R11 unmapped", d, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule